// File: doc/BRIEF.md
# Microcontroller Branch and Wait Sequencer

This block is the program-counter sequencer of a small command-processing microcontroller. In each cycle it sees the instruction fetched from the current program counter and the value of one register. The register is chosen by a read index that the block derives from that same instruction. From these two inputs it registers the next fetch address. It resolves four kinds of conditional relative branch. It performs absolute calls that save a return address on an internal stack of fixed depth, and returns that restore that address. It also runs a wait instruction that freezes fetch until an external ring write pointer moves.

Instructions without flow control advance the counter by one. The block keeps three status flags. A sticky stack error flag records any push into a full stack or pop from an empty one. A secure-mode flag is loaded by a dedicated opcode. An in-handler flag is set by an external pulse when an interrupt handler is entered, and it is cleared by a return that is marked as leaving that handler. The block does no ALU work, no control-register access and no preemption handling.

Top module: `flow_seq`

## Requirements
- R1: After the asynchronous reset the counter is 0 and stall_o, stack_err_o, secure_o and in_handler_o are all 0.
- R2: The opcode is instr_i[31:26]. Any opcode that is not listed in R3 to R10 moves the counter to pc+1 and has no other effect. reg_idx_o always equals instr_i[25:21].
- R3: Opcode 0x30 branches when the register value differs from the zero-extended immediate instr_i[20:16]. Opcode 0x31 branches when the two are equal, and the comparison uses all 32 bits. A taken branch loads pc + sign-extended instr_i[15:0], modulo 2^ADDR_W. An untaken branch loads pc+1.
- R4: Opcode 0x32 branches when register bit instr_i[20:16] is 0, and opcode 0x33 branches when that bit is 1. Target and fall-through are as in R3.
- R5: Opcode 0x35 (call) loads the counter from instr_i[ADDR_W-1:0] and pushes pc+1.
- R6: Opcode 0x34 (return) loads the most recently pushed address and removes it, so nested calls return in last-in, first-out order.
- R7: A call made while STACK_DEPTH entries are held still jumps, but its return address is discarded. A return made on an empty stack moves to pc+1. Either event sets stack_err_o, which stays set until reset.
- R8: irq_enter_i sets in_handler_o. A return with instr_i[25]=1 clears in_handler_o, and a return with instr_i[25]=0 leaves it unchanged.
- R9: Opcode 0x3b loads secure_o from bit 0 of the register value and moves the counter to pc+1.
- R10: Opcode 0x36 (wait) captures wptr_i and raises stall_o from the next cycle. While stalled, the counter holds and instr_i is ignored.
- R11: In a stalled cycle where wptr_i differs from the captured value, the next edge drops stall_o and moves the counter to pc+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 32 | Instruction fetched at pc_o |
| reg_val_i | input | 32 | Value of register reg_idx_o |
| reg_idx_o | output | 5 | Register read index for the current instruction |
| wptr_i | input | PTR_W | External ring write pointer |
| irq_enter_i | input | 1 | Pulse marking entry into an interrupt handler |
| pc_o | output | ADDR_W | Current fetch address |
| stall_o | output | 1 | Fetch held by a pending wait |
| stack_err_o | output | 1 | Sticky return-stack overflow/underflow flag |
| secure_o | output | 1 | Secure-mode status |
| in_handler_o | output | 1 | Interrupt-handler status |

## Verification
A wrong branch decision or a bad target shows on pc_o one edge after the instruction is presented, so every step of the vector program checks the counter right after the next edge. A corrupted return-stack slot or pointer stays hidden until the matching return, so the bench returns from a full stack in order and then pops once more to show that the discarded entry never existed. A wait snapshot or stall state that goes wrong shows as a counter that moves too early or never releases. An instruction that leaks through a stall shows up on a later return, where an address pushed by mistake would replace the expected underflow.

// File: rtl/flow_seq_pkg.sv
package flow_seq_pkg;

  localparam logic [5:0] OPC_BR_NE_IMM = 6'h30;
  localparam logic [5:0] OPC_BR_EQ_IMM = 6'h31;
  localparam logic [5:0] OPC_BR_BIT_CLR = 6'h32;
  localparam logic [5:0] OPC_BR_BIT_SET = 6'h33;
  localparam logic [5:0] OPC_RETURN = 6'h34;
  localparam logic [5:0] OPC_CALL = 6'h35;
  localparam logic [5:0] OPC_WAIT_PTR = 6'h36;
  localparam logic [5:0] OPC_SET_SECURE = 6'h3b;

  typedef enum logic [2:0] {
    ACT_STEP,
    ACT_JUMP,
    ACT_CALL,
    ACT_RET,
    ACT_WAIT,
    ACT_SECURE
  } seq_act_e;

endpackage

// File: rtl/flow_seq_decode.sv
module flow_seq_decode
  import flow_seq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [31:0]       instr_i,
  input  logic [31:0]       reg_val_i,
  input  logic [ADDR_W-1:0] pc_i,
  output logic [4:0]        reg_idx_o,
  output seq_act_e          act_o,
  output logic [ADDR_W-1:0] br_target_o,
  output logic [ADDR_W-1:0] call_target_o,
  output logic              int_ret_o
);

  logic [5:0]  opc;
  logic [4:0]  imm5;
  logic [31:0] off_ext;
  logic [31:0] pc_ext;
  logic [31:0] sum;
  logic        eq_imm;
  logic        bit_val;

  assign opc       = instr_i[31:26];
  assign imm5      = instr_i[20:16];
  assign reg_idx_o = instr_i[25:21];
  assign int_ret_o = instr_i[25];

  assign off_ext = {{16{instr_i[15]}}, instr_i[15:0]};
  assign pc_ext  = {{(32-ADDR_W){1'b0}}, pc_i};
  assign sum     = pc_ext + off_ext;
  assign br_target_o   = sum[ADDR_W-1:0];
  assign call_target_o = instr_i[ADDR_W-1:0];

  assign eq_imm  = (reg_val_i == {27'd0, imm5});
  assign bit_val = reg_val_i[imm5];

  always_comb begin
    act_o = ACT_STEP;
    unique case (opc)
      OPC_BR_NE_IMM:  act_o = eq_imm   ? ACT_STEP : ACT_JUMP;
      OPC_BR_EQ_IMM:  act_o = eq_imm   ? ACT_JUMP : ACT_STEP;
      OPC_BR_BIT_CLR: act_o = bit_val  ? ACT_STEP : ACT_JUMP;
      OPC_BR_BIT_SET: act_o = bit_val  ? ACT_JUMP : ACT_STEP;
      OPC_RETURN:     act_o = ACT_RET;
      OPC_CALL:       act_o = ACT_CALL;
      OPC_WAIT_PTR:   act_o = ACT_WAIT;
      OPC_SET_SECURE: act_o = ACT_SECURE;
      default:        act_o = ACT_STEP;
    endcase
  end

  // R3/R4: opcodes outside the flow range never request a jump
  always_comb begin
    assert_low_opc_steps_R2: assert (opc >= 6'h30 || act_o == ACT_STEP)
      else $error("low opcode decoded as flow control");
  end

endmodule

// File: rtl/flow_seq_stack.sv
module flow_seq_stack #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [ADDR_W-1:0] data_i,
  output logic [ADDR_W-1:0] top_o,
  output logic              empty_o,
  output logic              ovf_o,
  output logic              udf_o
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] slot_q [DEPTH];
  logic              full;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [IDX_W-1:0]  top_idx;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign wr_en   = push_i && !full;
  assign ovf_o   = push_i && full;
  assign udf_o   = pop_i && empty_o;
  assign wr_idx  = IDX_W'(cnt_q);
  assign top_idx = IDX_W'(cnt_q - CNT_W'(1));
  assign top_o   = empty_o ? '0 : slot_q[top_idx];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) slot_q[i] <= '0;
      else if (wr_en && wr_idx == IDX_W'(i)) slot_q[i] <= data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (wr_en) cnt_q <= cnt_q + CNT_W'(1);
    else if (pop_i && !empty_o) cnt_q <= cnt_q - CNT_W'(1);
  end

  assert_cnt_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));

  assert_ovf_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full) |=> cnt_q == $past(cnt_q));

  assert_pop_shrinks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !empty_o) |=> cnt_q == $past(cnt_q) - CNT_W'(1));

endmodule

// File: rtl/flow_seq_wait.sv
module flow_seq_wait #(
  parameter int PTR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [PTR_W-1:0] wptr_i,
  output logic             stall_o,
  output logic             release_o
);

  logic [PTR_W-1:0] snap_q;
  logic             stall_q;

  assign stall_o   = stall_q;
  assign release_o = stall_q && (wptr_i != snap_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stall_q <= 1'b0;
      snap_q  <= '0;
    end else if (start_i && !stall_q) begin
      stall_q <= 1'b1;
      snap_q  <= wptr_i;
    end else if (release_o) begin
      stall_q <= 1'b0;
    end
  end

  assert_release_clears_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_o |=> !stall_q);

  assert_wait_holds_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_q && !release_o) |=> stall_q);

endmodule

// File: rtl/flow_seq.sv
module flow_seq
  import flow_seq_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int STACK_DEPTH = 8,
  parameter int PTR_W       = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [31:0]       instr_i,
  input  logic [31:0]       reg_val_i,
  output logic [4:0]        reg_idx_o,
  input  logic [PTR_W-1:0]  wptr_i,
  input  logic              irq_enter_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic              stall_o,
  output logic              stack_err_o,
  output logic              secure_o,
  output logic              in_handler_o
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] pc_q, pc_d, pc_inc;
  logic [ADDR_W-1:0] br_target, call_target, stk_top;
  seq_act_e          act;
  logic              int_ret, active;
  logic              push, pop, stk_empty, ovf, udf;
  logic              wait_start, stall, release_w;
  logic              err_q, secure_q, inh_q;

  assign pc_inc = pc_q + ONE;

  flow_seq_decode #(.ADDR_W(ADDR_W)) u_dec (
    .instr_i      (instr_i),
    .reg_val_i    (reg_val_i),
    .pc_i         (pc_q),
    .reg_idx_o    (reg_idx_o),
    .act_o        (act),
    .br_target_o  (br_target),
    .call_target_o(call_target),
    .int_ret_o    (int_ret)
  );

  assign active     = !stall;
  assign push       = active && (act == ACT_CALL);
  assign pop        = active && (act == ACT_RET);
  assign wait_start = active && (act == ACT_WAIT);

  flow_seq_stack #(.DEPTH(STACK_DEPTH), .ADDR_W(ADDR_W)) u_stk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push),
    .pop_i  (pop),
    .data_i (pc_inc),
    .top_o  (stk_top),
    .empty_o(stk_empty),
    .ovf_o  (ovf),
    .udf_o  (udf)
  );

  flow_seq_wait #(.PTR_W(PTR_W)) u_wait (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (wait_start),
    .wptr_i   (wptr_i),
    .stall_o  (stall),
    .release_o(release_w)
  );

  always_comb begin
    pc_d = pc_inc;
    if (stall) begin
      pc_d = release_w ? pc_inc : pc_q;
    end else begin
      unique case (act)
        ACT_JUMP: pc_d = br_target;
        ACT_CALL: pc_d = call_target;
        ACT_RET:  pc_d = stk_empty ? pc_inc : stk_top;
        ACT_WAIT: pc_d = pc_q;
        default:  pc_d = pc_inc;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q     <= '0;
      err_q    <= 1'b0;
      secure_q <= 1'b0;
      inh_q    <= 1'b0;
    end else begin
      pc_q <= pc_d;
      if (ovf || udf) err_q <= 1'b1;
      if (active && act == ACT_SECURE) secure_q <= reg_val_i[0];
      if (irq_enter_i) inh_q <= 1'b1;
      else if (pop && int_ret) inh_q <= 1'b0;
    end
  end

  assign pc_o         = pc_q;
  assign stall_o      = stall;
  assign stack_err_o  = err_q;
  assign secure_o     = secure_q;
  assign in_handler_o = inh_q;

  assert_err_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stack_err_o |=> stack_err_o);

  assert_stall_pc_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && !release_w) |=> $stable(pc_o));

  assert_wait_issue_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_start |=> (stall_o && $stable(pc_o)));

  assert_release_step_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_w |=> (!stall_o && pc_o == ADDR_W'($past(pc_o) + ONE)));

  assert_no_push_stalled_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> !push && !pop);

  assert_int_ret_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop && int_ret && !irq_enter_i) |=> !in_handler_o);

endmodule

// File: tb/flow_seq_test.sv
module flow_seq_test;

  localparam int ADDR_W = 16;
  localparam int PTR_W  = 16;
  localparam int NVEC   = 13;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [31:0]       instr_i = '0;
  logic [31:0]       reg_val_i = '0;
  logic [4:0]        reg_idx_o;
  logic [PTR_W-1:0]  wptr_i = '0;
  logic              irq_enter_i = 1'b0;
  logic [ADDR_W-1:0] pc_o;
  logic              stall_o, stack_err_o, secure_o, in_handler_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #4ns clk_i = ~clk_i;

  flow_seq #(.ADDR_W(ADDR_W), .STACK_DEPTH(8), .PTR_W(PTR_W)) uut (
    .clk_i, .rst_ni, .instr_i, .reg_val_i, .reg_idx_o, .wptr_i, .irq_enter_i,
    .pc_o, .stall_o, .stack_err_o, .secure_o, .in_handler_o
  );

  // {instr, reg value, expected pc after the edge}; program starts at pc 0
  localparam logic [79:0] VECS [NVEC] = '{
    {6'h00, 26'h0,                      32'h0000_0000, 16'h0001},
    {6'h31, 5'd1, 5'd5,  16'h0004,      32'h0000_0005, 16'h0005},
    {6'h30, 5'd2, 5'd5,  16'h0004,      32'h0000_0005, 16'h0006},
    {6'h30, 5'd3, 5'd5,  16'hFFFD,      32'h0000_0007, 16'h0003},
    {6'h33, 5'd4, 5'd8,  16'h000A,      32'h0000_0100, 16'h000D},
    {6'h32, 5'd4, 5'd8,  16'h0003,      32'h0000_0100, 16'h000E},
    {6'h32, 5'd5, 5'd31, 16'h0002,      32'h0000_0000, 16'h0010},
    {6'h33, 5'd6, 5'd0,  16'h0008,      32'hFFFF_FFFE, 16'h0011},
    {6'h31, 5'd7, 5'd5,  16'h0008,      32'h0000_0025, 16'h0012},
    {32'h5000_1234,                     32'h0000_0000, 16'h0013},
    {6'h30, 5'd1, 5'd0,  16'hFFED,      32'h0000_0001, 16'h0000},
    {6'h30, 5'd1, 5'd0,  16'hFFFF,      32'h0000_0001, 16'hFFFF},
    {6'h00, 26'h0,                      32'h0000_0000, 16'h0000}
  };

  function automatic logic [31:0] op_call(input logic [25:0] a);
    return {6'h35, a};
  endfunction
  function automatic logic [31:0] op_ret(input logic intr);
    return {6'h34, intr, 25'h0};
  endfunction
  localparam logic [31:0] OP_NOP = 32'h0;
  localparam logic [31:0] OP_WIN = {6'h36, 26'h0};
  localparam logic [31:0] OP_SEC = {6'h3b, 26'h0};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] ins, input logic [31:0] rv);
    instr_i   = ins;
    reg_val_i = rv;
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    instr_i = '0;
    irq_enter_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    check("R1 pc", 32'(pc_o), 0);
    check("R1 flags", {28'h0, stall_o, stack_err_o, secure_o, in_handler_o}, 0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    do_reset();

    // R2 R3 R4: vector program
    for (int i = 0; i < NVEC; i++) begin
      instr_i   = VECS[i][79:48];
      reg_val_i = VECS[i][47:16];
      #1;
      check("R2 reg_idx", 32'(reg_idx_o), 32'(VECS[i][73:69]));
      step(VECS[i][79:48], VECS[i][47:16]);
      check($sformatf("R3 R4 vector %0d pc", i), 32'(pc_o), 32'(VECS[i][15:0]));
    end

    // R5 R6: nested call and return
    step(op_call(26'h100), 0); check("R5 call", 32'(pc_o), 32'h100);
    step(op_call(26'h200), 0); check("R5 nested call", 32'(pc_o), 32'h200);
    step(op_ret(1'b0), 0);     check("R6 ret inner", 32'(pc_o), 32'h101);
    step(op_ret(1'b0), 0);     check("R6 ret outer", 32'(pc_o), 32'h1);
    check("R7 no error", 32'(stack_err_o), 0);

    // R7: overflow
    for (int k = 0; k < 8; k++) step(op_call(26'(32'h40 + k)), 0);
    check("R7 eight pushes", 32'(stack_err_o), 0);
    step(op_call(26'h80), 0);
    check("R7 overflow jump", 32'(pc_o), 32'h80);
    check("R7 overflow err", 32'(stack_err_o), 1);
    for (int k = 7; k >= 1; k--) begin
      step(op_ret(1'b0), 0);
      check("R6 lifo", 32'(pc_o), 32'h40 + k);
    end
    step(op_ret(1'b0), 0); check("R6 first push", 32'(pc_o), 32'h2);
    step(op_ret(1'b0), 0); check("R7 dropped push", 32'(pc_o), 32'h3);

    // R7: underflow alone, sticky
    do_reset();
    step(op_ret(1'b0), 0); check("R7 underflow pc", 32'(pc_o), 1);
    check("R7 underflow err", 32'(stack_err_o), 1);
    step(OP_NOP, 0); check("R7 sticky", 32'(stack_err_o), 1);

    // R8: handler status
    do_reset();
    irq_enter_i = 1'b1; step(OP_NOP, 0); irq_enter_i = 1'b0;
    check("R8 set", 32'(in_handler_o), 1);
    step(op_call(26'h10), 0); step(op_ret(1'b0), 0);
    check("R8 plain ret pc", 32'(pc_o), 2);
    check("R8 plain ret keeps", 32'(in_handler_o), 1);
    step(op_call(26'h20), 0); step(op_ret(1'b1), 0);
    check("R8 int ret pc", 32'(pc_o), 3);
    check("R8 int ret clears", 32'(in_handler_o), 0);

    // R9: secure
    step(OP_SEC, 32'h1);         check("R9 set", 32'(secure_o), 1);
    check("R9 pc", 32'(pc_o), 4);
    step(OP_SEC, 32'hFFFF_FFFE); check("R9 clear", 32'(secure_o), 0);
    step(OP_SEC, 32'h3);         check("R9 bit0", 32'(secure_o), 1);

    // R10 R11: wait
    wptr_i = 16'd5;
    step(OP_WIN, 0);
    check("R10 stall", 32'(stall_o), 1);
    check("R10 pc hold", 32'(pc_o), 6);
    step(op_call(26'h300), 0);
    check("R10 call ignored", 32'(pc_o), 6);
    step(OP_NOP, 0);
    check("R10 still stalled", 32'(stall_o), 1);
    wptr_i = 16'd6;
    step(OP_NOP, 0);
    check("R11 release", 32'(stall_o), 0);
    check("R11 advance", 32'(pc_o), 7);
    step(OP_WIN, 0);
    step(OP_NOP, 0);
    check("R11 new snapshot", 32'(stall_o), 1);
    check("R10 hold 2", 32'(pc_o), 7);
    wptr_i = 16'd9;
    step(OP_NOP, 0);
    check("R11 release 2", 32'(pc_o), 8);
    check("R10 err clean", 32'(stack_err_o), 0);
    step(op_ret(1'b0), 0);
    check("R10 nothing pushed", 32'(pc_o), 9);
    check("R10 underflow seen", 32'(stack_err_o), 1);

    finish_run();
  end

endmodule